// File: doc/BRIEF.md
# Serial Receiver with Flagged Character Queue

This block turns an asynchronous serial line into a queue of characters. An oversampling tick (sixteen ticks per bit by default) drives a small state machine that finds the start bit, checks it at mid-bit, then collects five to eight data bits, an optional parity bit and a stop bit. Every finished character enters a 64-entry queue along with three flags of its own: parity error, framing error and line break. The head of the queue is always visible at the output, and a pop strobe removes it.

Around the queue sit four indications. A level output goes high when the queue holds at least a programmed number of characters. A flow-control output tells the remote sender to pause once occupancy reaches a halt level and releases it only when occupancy has dropped to a separate, lower resume level. An overflow flag records a character lost to a full queue. An idle flag reports that characters are waiting but the line has been quiet for four character times.

Top module: `serial_rx_queue`

## Requirements
- R1: The line rests high. A falling edge starts a frame only if the line is still low half a bit period later; if it has gone high by then, nothing is stored and the receiver waits for the next falling edge.
- R2: `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0 to 3). The first data bit received lands in bit 0 of `head_data`, and the bits above the selected length read as zero.
- R3: With `cfg_par_en` high, one parity bit follows the data. `head_perr` is set when the count of ones over data plus parity bit is odd with `cfg_par_odd` low (even mode), or even with `cfg_par_odd` high (odd mode). With parity off, `head_perr` is always 0.
- R4: `head_ferr` is set when the stop bit is sampled low.
- R5: A frame that is low from start bit through stop bit is a break: one entry is stored with data 0, `head_brk` 1, `head_ferr` 1 and `head_perr` 0, and no further frame starts until the line has returned high.
- R6: The queue holds 64 characters in arrival order. `head_valid` is high whenever it is non-empty, and a pop on an empty queue has no effect.
- R7: A character finishing while the queue is full and no pop happens in that cycle is dropped and sets `ovf_flag`. A pop clears `ovf_flag` unless a drop happens in the same cycle. A character finishing in the same cycle as a pop of a full queue is kept.
- R8: `level_hit` is high exactly when occupancy is at least `cfg_trig_lvl`.
- R9: `flow_stop` rises the cycle after occupancy reaches `cfg_halt_lvl`, falls the cycle after occupancy is at or below `cfg_resume_lvl`, and holds its value in between.
- R10: `idle_flag` rises once the queue is non-empty and the receiver has sat idle for four character times, where one character time is `OVS*(7+cfg_len+cfg_par_en)` ticks. A pop or a new start bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, OVS per bit |
| rx_serial | input | 1 | Serial line input |
| cfg_len | input | 2 | Data length code: 0=5 .. 3=8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_trig_lvl | input | 7 | Occupancy for `level_hit` |
| cfg_halt_lvl | input | 7 | Occupancy that raises `flow_stop` |
| cfg_resume_lvl | input | 7 | Occupancy that releases `flow_stop` |
| pop | input | 1 | Remove the head character |
| head_valid | output | 1 | Queue is non-empty |
| head_data | output | 8 | Head character data |
| head_perr | output | 1 | Head parity error |
| head_ferr | output | 1 | Head framing error |
| head_brk | output | 1 | Head is a break |
| level_hit | output | 1 | Occupancy at or above trigger |
| flow_stop | output | 1 | Ask remote sender to pause |
| ovf_flag | output | 1 | A character was lost |
| idle_flag | output | 1 | Data waiting, line quiet |

## Verification
The completion of a character and a pop of the queue can land in the same cycle, and at full occupancy that meeting decides whether a character is kept or lost. The bench fills the queue to 64, then counts clock cycles from the start bit of the next frame so that the pop strobe is high exactly in the cycle the new character is written. It judges the outcome by an overflow flag that stays low, an unchanged level indication, and a later drain in which the new character appears last after the 63 survivors; a further frame without a pop must then be dropped and raise the flag.

// File: rtl/srxq_pkg.sv
package srxq_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAITHI
    } rx_state_e;

endpackage

// File: rtl/srxq_sampler.sv
module srxq_sampler
    import srxq_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic [1:0] cfg_len_i,
    input  logic       cfg_par_en_i,
    input  logic       cfg_par_odd_i,
    output logic       push_o,
    output rx_char_t   char_o,
    output logic       line_idle_o
);

    localparam int TW = $clog2(OVS);
    localparam logic [TW-1:0] HALF = TW'(OVS / 2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OVS - 1);

    typedef struct packed {
        logic [1:0]      sync;
        rx_state_e       st;
        logic [TW-1:0]   tcnt;
        logic [2:0]      bidx;
        logic [7:0]      sh;
        logic            par;
        logic            push;
        rx_char_t        ch;
    } smp_t;

    localparam smp_t SMP_RST = '{sync: 2'b11, st: RX_IDLE, default: '0};

    smp_t q, d;
    logic rxs;
    logic [2:0] last_bit;
    logic brk_now;

    assign rxs      = q.sync[1];
    assign last_bit = {1'b0, cfg_len_i} + 3'd4;
    assign brk_now  = !rxs && (q.sh == 8'h00) && !(cfg_par_en_i && q.par);

    always_comb begin
        d      = q;
        d.push = 1'b0;
        d.sync = {q.sync[0], rx_i};
        if (tick_i) begin
            case (q.st)
                RX_IDLE: begin
                    if (!rxs) begin
                        d.st   = RX_START;
                        d.tcnt = '0;
                    end
                end
                RX_START: begin
                    if (q.tcnt == HALF) begin
                        d.tcnt = '0;
                        if (rxs) begin
                            d.st = RX_IDLE;
                        end else begin
                            d.st   = RX_DATA;
                            d.bidx = '0;
                            d.sh   = '0;
                            d.par  = 1'b0;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.tcnt == LAST) begin
                        d.tcnt         = '0;
                        d.sh[q.bidx]   = rxs;
                        if (q.bidx == last_bit) begin
                            d.st = cfg_par_en_i ? RX_PAR : RX_STOP;
                        end else begin
                            d.bidx = q.bidx + 1'b1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (q.tcnt == LAST) begin
                        d.tcnt = '0;
                        d.par  = rxs;
                        d.st   = RX_STOP;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.tcnt == LAST) begin
                        d.tcnt      = '0;
                        d.push      = 1'b1;
                        d.ch.data   = q.sh;
                        d.ch.ferr   = !rxs;
                        d.ch.brk    = brk_now;
                        d.ch.perr   = cfg_par_en_i && !brk_now &&
                                      (((^q.sh) ^ q.par) != cfg_par_odd_i);
                        d.st        = rxs ? RX_IDLE : RX_WAITHI;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_WAITHI: begin
                    if (rxs) begin
                        d.st = RX_IDLE;
                    end
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SMP_RST;
        end else begin
            q <= d;
        end
    end

    assign push_o      = q.push;
    assign char_o      = q.ch;
    assign line_idle_o = (q.st == RX_IDLE);

    AST_BRK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && char_o.brk) |-> (char_o.data == 8'h00 && char_o.ferr && !char_o.perr)); // R5

    AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o); // R4

endmodule

// File: rtl/srxq_fifo.sv
module srxq_fifo
    import srxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  rx_char_t                     din_i,
    input  logic                         pop_i,
    output rx_char_t                     dout_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         drop_o
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t q, d;
    rx_char_t mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop_i && (q.cnt != '0);
        do_push = push_i && ((q.cnt != FULL_CNT) || do_pop);
        drop_o  = push_i && !do_push;
        if (do_push) d.wptr = step(q.wptr);
        if (do_pop)  d.rptr = step(q.rptr);
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[q.wptr] <= din_i;
        end
    end

    assign dout_o  = mem[q.rptr];
    assign count_o = q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL_CNT); // R6

    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> $stable(count_o)); // R7

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import srxq_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_serial,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [6:0] cfg_trig_lvl,
    input  logic [6:0] cfg_halt_lvl,
    input  logic [6:0] cfg_resume_lvl,
    input  logic       pop,
    output logic       head_valid,
    output logic [7:0] head_data,
    output logic       head_perr,
    output logic       head_ferr,
    output logic       head_brk,
    output logic       level_hit,
    output logic       flow_stop,
    output logic       ovf_flag,
    output logic       idle_flag
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(4 * OVS * 12 + 1);

    typedef struct packed {
        logic          ovf;
        logic          flow;
        logic [IW-1:0] icnt;
    } top_t;

    top_t q, d;

    logic          push;
    rx_char_t      in_char;
    rx_char_t      head;
    logic          line_idle;
    logic [CW-1:0] count;
    logic          drop;
    logic [6:0]    cnt7;
    logic [IW-1:0] idle_lim;
    logic          pop_eff;

    srxq_sampler #(.OVS(OVS)) u_smp (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (os_tick),
        .rx_i         (rx_serial),
        .cfg_len_i    (cfg_len),
        .cfg_par_en_i (cfg_par_en),
        .cfg_par_odd_i(cfg_par_odd),
        .push_o       (push),
        .char_o       (in_char),
        .line_idle_o  (line_idle)
    );

    srxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .din_i  (in_char),
        .pop_i  (pop),
        .dout_o (head),
        .count_o(count),
        .drop_o (drop)
    );

    assign cnt7     = 7'(count);
    assign pop_eff  = pop && (count != '0);
    assign idle_lim = IW'((4 * OVS) * (7 + int'(cfg_len) + int'(cfg_par_en)));

    always_comb begin
        d = q;
        // overflow: a drop sets, a pop clears, a drop wins a tie
        if (drop) begin
            d.ovf = 1'b1;
        end else if (pop_eff) begin
            d.ovf = 1'b0;
        end
        // flow control with separate halt and resume points
        if (cnt7 >= cfg_halt_lvl) begin
            d.flow = 1'b1;
        end else if (cnt7 <= cfg_resume_lvl) begin
            d.flow = 1'b0;
        end
        // quiet-line timer, runs only while data waits
        if (!line_idle || (count == '0) || pop) begin
            d.icnt = '0;
        end else if (os_tick && (q.icnt < idle_lim)) begin
            d.icnt = q.icnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_valid = (count != '0);
    assign head_data  = head.data;
    assign head_perr  = head.perr;
    assign head_ferr  = head.ferr;
    assign head_brk   = head.brk;
    assign level_hit  = (cnt7 >= cfg_trig_lvl);
    assign flow_stop  = q.flow;
    assign ovf_flag   = q.ovf;
    assign idle_flag  = (q.icnt >= idle_lim) && (count != '0);

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_flag); // R7

    AST_FLOW_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt7 >= cfg_halt_lvl) |=> flow_stop); // R9

    AST_FLOW_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt7 <= cfg_resume_lvl) && (cnt7 < cfg_halt_lvl)) |=> !flow_stop); // R9

    AST_IDLE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        idle_flag |-> head_valid); // R10

    AST_IDLE_NOT_RECV: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !pop) |-> line_idle); // R10

endmodule

// File: tb/sim_serial_rx_queue.sv
module sim_serial_rx_queue;

    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rx = 1'b1;
    logic [1:0] len = 2'd3;
    logic       pen = 1'b0;
    logic       podd = 1'b0;
    logic [6:0] trig = 7'd1;
    logic [6:0] halt = 7'd64;
    logic [6:0] resume = 7'd0;
    logic       pop = 1'b0;

    logic       head_valid, head_perr, head_ferr, head_brk;
    logic [7:0] head_data;
    logic       level_hit, flow_stop, ovf_flag, idle_flag;

    int checks = 0;
    int errors = 0;

    serial_rx_queue u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(tick), .rx_serial(rx),
        .cfg_len(len), .cfg_par_en(pen), .cfg_par_odd(podd),
        .cfg_trig_lvl(trig), .cfg_halt_lvl(halt), .cfg_resume_lvl(resume),
        .pop(pop), .head_valid(head_valid), .head_data(head_data),
        .head_perr(head_perr), .head_ferr(head_ferr), .head_brk(head_brk),
        .level_hit(level_hit), .flow_stop(flow_stop), .ovf_flag(ovf_flag),
        .idle_flag(idle_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] dat, input int nb, input bit pe,
                              input bit po, input bit bad, input bit stopv);
        logic [7:0] m;
        m = 8'((1 << nb) - 1);
        drive(1'b0, OVS);
        for (int i = 0; i < nb; i++) drive(dat[i], OVS);
        if (pe) drive((^(dat & m)) ^ po ^ bad, OVS);
        drive(stopv, OVS);
        rx = 1'b1;
        if (!stopv) drive(1'b1, OVS);
    endtask

    task automatic pop_one();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit fmod;
        int n;
        logic [7:0] dv, m, expd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset valid", head_valid, 0);
        chk("R8 reset level", level_hit, 0);
        chk("R9 reset flow", flow_stop, 0);
        chk("R7 reset ovf", ovf_flag, 0);
        chk("R10 reset idle", idle_flag, 0);

        // R2 R3 sweep: every length, parity none/even/odd, four patterns
        for (int l = 0; l < 4; l++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 4; k++) begin
                    len  = 2'(l);
                    pen  = (pm != 0);
                    podd = (pm == 2);
                    dv   = 8'(37 * k + 11 * l + 5 * pm + 1);
                    m    = 8'((1 << (l + 5)) - 1);
                    send_frame(dv, l + 5, pen, podd, 1'b0, 1'b1);
                    chk("R2 valid", head_valid, 1);
                    chk("R2 data", head_data, dv & m);
                    chk("R3 perr clean", head_perr, 0);
                    chk("R4 ferr clean", head_ferr, 0);
                    pop_one();
                    chk("R6 empty after pop", head_valid, 0);
                end
            end
        end

        // R3 parity error in both modes
        len = 2'd3;
        for (int pm = 1; pm < 3; pm++) begin
            pen  = 1'b1;
            podd = (pm == 2);
            send_frame(8'h6B, 8, 1'b1, podd, 1'b1, 1'b1);
            chk("R3 perr set", head_perr, 1);
            chk("R3 data kept", head_data, 8'h6B);
            pop_one();
        end
        pen = 1'b0; podd = 1'b0;

        // R4 framing error
        send_frame(8'h55, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 ferr", head_ferr, 1);
        chk("R4 not break", head_brk, 0);
        chk("R4 data", head_data, 8'h55);
        pop_one();

        // R5 break: long low line, exactly one entry
        drive(1'b0, 200);
        drive(1'b1, 32);
        chk("R5 valid", head_valid, 1);
        chk("R5 brk", head_brk, 1);
        chk("R5 ferr", head_ferr, 1);
        chk("R5 perr", head_perr, 0);
        chk("R5 data zero", head_data, 0);
        pop_one();
        chk("R5 single entry", head_valid, 0);

        // R1 short low pulses rejected
        drive(1'b0, 4);
        drive(1'b1, 64);
        chk("R1 glitch4 ignored", head_valid, 0);
        drive(1'b0, 6);
        drive(1'b1, 200);
        chk("R1 glitch6 ignored", head_valid, 0);
        chk("R1 no ovf", ovf_flag, 0);

        // R6 pop on empty has no effect
        pop_one();
        chk("R6 pop empty", head_valid, 0);

        // R10 idle timer: 4 * 16 * 10 = 640 ticks for 8N1
        send_frame(8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 idle early", idle_flag, 0);
        repeat (600) @(negedge clk);
        chk("R10 idle before limit", idle_flag, 0);
        repeat (60) @(negedge clk);
        chk("R10 idle after limit", idle_flag, 1);
        pop_one();
        chk("R10 idle cleared by pop", idle_flag, 0);

        // R8 R9 fill to full
        trig = 7'd10; halt = 7'd48; resume = 7'd16;
        @(negedge clk);
        fmod = 1'b0;
        for (int i = 0; i < 64; i++) begin
            send_frame(8'(i), 8, 1'b0, 1'b0, 1'b0, 1'b1);
            n = i + 1;
            if (n >= 48) fmod = 1'b1;
            else if (n <= 16) fmod = 1'b0;
            chk("R8 level fill", level_hit, (n >= 10));
            chk("R9 flow fill", flow_stop, fmod);
        end

        // R7 character completes in the same cycle as a pop of a full queue
        fork
            send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b1);
            begin
                repeat (155) @(negedge clk);
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end
        join
        chk("R7 no ovf on push+pop", ovf_flag, 0);
        chk("R8 still full", level_hit, 1);
        chk("R6 head after coincident pop", head_data, 8'h01);

        // R7 true overflow
        send_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 ovf set", ovf_flag, 1);
        chk("R7 head unchanged", head_data, 8'h01);

        // R6 R7 R8 R9 drain
        for (int i = 0; i < 64; i++) begin
            expd = (i < 63) ? 8'(i + 1) : 8'hA5;
            chk("R6 order", head_data, expd);
            pop_one();
            n = 63 - i;
            if (i == 0) chk("R7 ovf cleared by pop", ovf_flag, 0);
            if (n >= 48) fmod = 1'b1;
            else if (n <= 16) fmod = 1'b0;
            chk("R9 flow drain", flow_stop, fmod);
            chk("R8 level drain", level_hit, (n >= 10));
        end
        chk("R6 drained", head_valid, 0);

        finish_run();
    end

endmodule